// File: doc/BRIEF.md
# Device Control and Status Register File

This block is the register front end of a USB device controller core. A plain 32-bit register port, with one write strobe, one read strobe, a byte address and a write and a read data word, reaches four words: a configuration word made of command strobes, a read-only status word, a command word that carries the function address, and a link-tuning word. The protocol engines, PHY and DMA sit outside the block. They use the control outputs it drives, and they supply the speed, VBUS and link-state inputs that the status word reports.

Software never needs a read-modify-write on this block. Each feature has its own turn-on bit and its own turn-off bit in the configuration word, and a write of 0 to either bit leaves the feature alone. The function address and each link-tuning field are committed only when a companion commit bit is 1 in the same write. Those commit bits, like every strobe, read back as 0. Bit 7 of the configuration word starts a software reset. It returns the feature states and the function address to their reset values and holds the ready flag in the status word low for a fixed number of cycles.

Word map, selected by address bits [ADDR_W-1:2], with bits [1:0] ignored: 0x00 configuration, 0x04 status, 0x08 command, 0x0C link tuning. Every other word is unmapped.

Top module: `dctl_regs`

## Requirements
- R1: In the configuration word, a 1 written to a turn-on bit sets its feature: device enable on bit 14, L1 entry on bit 16, U1 entry on bit 24, U2 entry on bit 26. The status word shows these at bits 14, 16, 24 and 25. A 1 written to the turn-off bit (15, 17, 25, 27) clears the feature.
- R2: A configuration bit written as 0 leaves its feature unchanged. A feature changes only on a write to the configuration word.
- R3: When a write carries both the turn-on and the turn-off bit of one feature, the feature ends up off.
- R4: Further pairs in the configuration word, written as turn-on/turn-off. Force full speed is 13/12 and drives the `force_fs` output. DMA clock turn-off is 10/11 and shows at status bit 30. HS/FS clock turn-off is 18/19 and shows at status bit 8. SS clock turn-off is 21/22 and shows at status bit 9.
- R5: The 7-bit function address in command bits [7:1] is stored only when command bit 0 is 1 in the same write. A command read returns the stored address in [7:1] with 0 everywhere else. Status bit 15 is 1 exactly when the stored address is nonzero.
- R6: The link-tuning word holds four fields: [7:0], [15:8], [16] and [21:17]. Each field is stored only when its commit bit (24, 25, 26, 27 in that order) is 1 in the same write. A tuning read returns the stored fields, and bits 24 to 27 read 0.
- R7: The status word reports the `speed_in` input at bits [6:4], `vbus_in` at bit 17 and `link_state_in` at bits [29:26].
- R8: After hardware reset, all features are off except the two clock turn-off states, which read 1. The status endianness bits 7 and 31 read 0, status bit 10 reads 1, and the function address and all tuning fields are 0.
- R9: Writing 1 to configuration bit 7 puts every feature and the function address back to their reset values, whatever else the same write carries. For the 4 cycles that follow the write edge, status bit 10 and `core_ready` read 0; after that they read 1. Tuning fields are kept.
- R10: Reads take one cycle. Read data is valid in the cycle after the read strobe and is 0 in any cycle that follows no read. Reads of the configuration word and of unmapped words return 0.
- R11: Writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| speed_in | input | 3 | Connected speed code (0 undefined, 1 low, 2 full, 3 high, 4 super) |
| vbus_in | input | 1 | VBUS detected |
| link_state_in | input | 4 | SuperSpeed link state code |
| dev_en | output | 1 | Device enabled |
| l1_en | output | 1 | L1 entry allowed |
| u1_en | output | 1 | U1 entry allowed |
| u2_en | output | 1 | U2 entry allowed |
| force_fs | output | 1 | Force full speed |
| dma_clk_off | output | 1 | DMA clock turn-off allowed |
| hs_clk_off | output | 1 | HS/FS clock turn-off allowed |
| ss_clk_off | output | 1 | SS clock turn-off allowed |
| func_addr | output | 7 | Stored function address |
| core_ready | output | 1 | Internal reset released |
| tune_u1_det | output | 8 | Tuning field 0 |
| tune_u1_gen | output | 8 | Tuning field 1 |
| tune_rx_hold | output | 1 | Tuning field 2 |
| tune_ping | output | 5 | Tuning field 3 |

## Verification
The software-reset window is the hardest behaviour to observe from the ports. It lasts only four cycles, it starts on the write edge, and it is visible only through status bit 10. To catch it, the bench loads features, an address and tuning fields, issues a reset write that also carries a turn-on bit, and follows it with back-to-back status reads. The expected sequence is four reads of 0 for the ready bit and then a 1. The clear-wins case and the commit-bit gating are reached with single writes that mix several bits, each followed by a read and a port check.

// File: rtl/dctl_pkg.sv
// Shared constants for the device control register file: word indices,
// bit positions of the turn-on/turn-off pairs and link-tuning field layout.
package dctl_pkg;
    localparam int DATA_W    = 32;
    localparam int IDX_CFG   = 0;
    localparam int IDX_STS   = 1;
    localparam int IDX_CMD   = 2;
    localparam int IDX_TUNE  = 3;

    // Feature order: dev, l1, u1, u2, force_fs, dma_off, hs_clk_off, ss_clk_off
    localparam int NUM_FEAT = 8;
    localparam int FEAT_ON_POS  [NUM_FEAT] = '{14, 16, 24, 26, 13, 10, 18, 21};
    localparam int FEAT_OFF_POS [NUM_FEAT] = '{15, 17, 25, 27, 12, 11, 19, 22};
    localparam logic [NUM_FEAT-1:0] FEAT_RST = 8'b1100_0000;

    localparam int CFG_SWRST  = 7;
    localparam int CMD_COMMIT = 0;
    localparam int FADDR_W    = 7;
    localparam int SPEED_W    = 3;
    localparam int LINK_W     = 4;
    localparam int RST_HOLD   = 4;

    localparam int NUM_TUNE = 4;
    localparam int TUNE_W      [NUM_TUNE] = '{8, 8, 1, 5};
    localparam int TUNE_LSB    [NUM_TUNE] = '{0, 8, 16, 17};
    localparam int TUNE_COMMIT [NUM_TUNE] = '{24, 25, 26, 27};
    localparam int TUNE_TOTAL  = 22;
endpackage

// File: rtl/dctl_field.sv
// Holding register for one field that is written only together with a
// commit bit. Assumes wr and commit are single-cycle qualifiers; clr wins.
module dctl_field #(
    parameter int W = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic         commit,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Store d on a committed write, return to RST on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)            q <= RST;
        else if (clr)          q <= RST;
        else if (wr && commit) q <= d;
    end
endmodule

// File: rtl/dctl_pair_bank.sv
// Bank of N feature flags, each driven by its own turn-on and turn-off
// strobe. A turn-off strobe wins over a turn-on strobe; soft reset wins
// over both. Assumes strobes are already qualified by the write.
module dctl_pair_bank #(
    parameter int N = 8,
    parameter logic [N-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] on_vec,
    input  logic [N-1:0] off_vec,
    output logic [N-1:0] state
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: reset value, then off over on, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) state[i] <= RST[i];
            else if (off_vec[i])    state[i] <= 1'b0;
            else if (on_vec[i])     state[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/dctl_rst_seq.sv
// Internal reset window: a start pulse holds busy high for exactly HOLD
// cycles after the start edge. A new start restarts the window.
module dctl_rst_seq #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    // Load the window length on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= CW'(HOLD);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dctl_regs.sv
// Device control/status register file. Decodes a simple word-addressed
// register port into turn-on/turn-off feature flags, a commit-gated
// function address, commit-gated link-tuning fields and a read-only status
// word. Assumes one access per cycle; reads return data one cycle later.
module dctl_regs
    import dctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [2:0]        speed_in,
    input  logic              vbus_in,
    input  logic [3:0]        link_state_in,
    output logic              dev_en,
    output logic              l1_en,
    output logic              u1_en,
    output logic              u2_en,
    output logic              force_fs,
    output logic              dma_clk_off,
    output logic              hs_clk_off,
    output logic              ss_clk_off,
    output logic [6:0]        func_addr,
    output logic              core_ready,
    output logic [7:0]        tune_u1_det,
    output logic [7:0]        tune_u1_gen,
    output logic              tune_rx_hold,
    output logic [4:0]        tune_ping
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]      widx;
    logic                  sel_cfg, sel_sts, sel_cmd, sel_tune;
    logic                  cfg_wr, cmd_wr, tune_wr, soft_rst, busy;
    logic [NUM_FEAT-1:0]   on_vec, off_vec, feat;
    logic [TUNE_TOTAL-1:0] tune_q;
    logic [DATA_W-1:0]     sts_word, rd_mux;
    wire                   unused_bits = ^{bus_wdata[31:28], bus_wdata[23], bus_addr[1:0]};

    assign widx     = bus_addr[ADDR_W-1:2];
    assign sel_cfg  = (widx == IDX_W'(IDX_CFG));
    assign sel_sts  = (widx == IDX_W'(IDX_STS));
    assign sel_cmd  = (widx == IDX_W'(IDX_CMD));
    assign sel_tune = (widx == IDX_W'(IDX_TUNE));
    assign cfg_wr   = bus_we && sel_cfg;
    assign cmd_wr   = bus_we && sel_cmd;
    assign tune_wr  = bus_we && sel_tune;
    assign soft_rst = cfg_wr && bus_wdata[CFG_SWRST];

    // Gather the turn-on/turn-off strobes of each feature from the write data.
    for (genvar i = 0; i < NUM_FEAT; i++) begin : g_strobe
        assign on_vec[i]  = cfg_wr && bus_wdata[FEAT_ON_POS[i]];
        assign off_vec[i] = cfg_wr && bus_wdata[FEAT_OFF_POS[i]];
    end

    dctl_pair_bank #(.N(NUM_FEAT), .RST(FEAT_RST)) u_feat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .on_vec   (on_vec),
        .off_vec  (off_vec),
        .state    (feat)
    );

    dctl_field #(.W(FADDR_W)) u_faddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .wr     (cmd_wr),
        .commit (bus_wdata[CMD_COMMIT]),
        .d      (bus_wdata[FADDR_W:1]),
        .q      (func_addr)
    );

    // One commit-gated holding register per link-tuning field.
    for (genvar k = 0; k < NUM_TUNE; k++) begin : g_tune
        dctl_field #(.W(TUNE_W[k])) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (1'b0),
            .wr     (tune_wr),
            .commit (bus_wdata[TUNE_COMMIT[k]]),
            .d      (bus_wdata[TUNE_LSB[k] +: TUNE_W[k]]),
            .q      (tune_q[TUNE_LSB[k] +: TUNE_W[k]])
        );
    end

    dctl_rst_seq #(.HOLD(RST_HOLD)) u_rseq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (soft_rst),
        .busy  (busy)
    );

    // Assemble the status word from internal state and external inputs.
    always_comb begin
        sts_word        = '0;
        sts_word[6:4]   = speed_in;
        sts_word[8]     = feat[6];
        sts_word[9]     = feat[7];
        sts_word[10]    = !busy;
        sts_word[14]    = feat[0];
        sts_word[15]    = (func_addr != '0);
        sts_word[16]    = feat[1];
        sts_word[17]    = vbus_in;
        sts_word[24]    = feat[2];
        sts_word[25]    = feat[3];
        sts_word[29:26] = link_state_in;
        sts_word[30]    = feat[5];
    end

    // Select the word addressed by a read; strobes and unmapped words read 0.
    always_comb begin
        rd_mux = '0;
        if (sel_sts)       rd_mux = sts_word;
        else if (sel_cmd)  rd_mux[FADDR_W:1] = func_addr;
        else if (sel_tune) rd_mux[TUNE_TOTAL-1:0] = tune_q;
    end

    // Register the read data; cycles without a read return 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign dev_en       = feat[0];
    assign l1_en        = feat[1];
    assign u1_en        = feat[2];
    assign u2_en        = feat[3];
    assign force_fs     = feat[4];
    assign dma_clk_off  = feat[5];
    assign hs_clk_off   = feat[6];
    assign ss_clk_off   = feat[7];
    assign core_ready   = !busy;
    assign tune_u1_det  = tune_q[7:0];
    assign tune_u1_gen  = tune_q[15:8];
    assign tune_rx_hold = tune_q[16];
    assign tune_ping    = tune_q[21:17];
endmodule

// File: rtl/dctl_regs_chk.sv
// Property checker for dctl_regs, attached by bind. Observes only the
// register port and the block outputs.
module dctl_regs_chk
    import dctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              dev_en,
    input logic [6:0]        func_addr,
    input logic [7:0]        tune_u1_det,
    input logic              core_ready
);
    localparam int IDX_W = ADDR_W - 2;
    logic [IDX_W-1:0] widx;
    logic cfg_w, cmd_w, tune_w;
    wire  unused_chk = ^{bus_wdata, bus_addr};

    assign widx   = bus_addr[ADDR_W-1:2];
    assign cfg_w  = bus_we && (widx == IDX_W'(IDX_CFG));
    assign cmd_w  = bus_we && (widx == IDX_W'(IDX_CMD));
    assign tune_w = bus_we && (widx == IDX_W'(IDX_TUNE));

    a_r1_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w && bus_wdata[14] && !bus_wdata[15] && !bus_wdata[7]) |=> dev_en);

    a_r3_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w && bus_wdata[15]) |=> !dev_en);

    a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_w |=> $stable(dev_en));

    a_r5_addr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !((cmd_w && bus_wdata[0]) || (cfg_w && bus_wdata[7])) |=> $stable(func_addr));

    a_r6_tune_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(tune_w && bus_wdata[24]) |=> $stable(tune_u1_det));

    a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w && bus_wdata[7]) |=> !core_ready);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == 32'h0));

    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (widx > IDX_W'(IDX_TUNE))) |=> (bus_rdata == 32'h0));
endmodule

bind dctl_regs dctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dev_en      (dev_en),
    .func_addr   (func_addr),
    .tune_u1_det (tune_u1_det),
    .core_ready  (core_ready)
);

// File: tb/tb_dctl_regs.sv
module tb_dctl_regs;
    localparam int AW = 6;
    localparam logic [AW-1:0] A_CFG = 6'h00, A_STS = 6'h04, A_CMD = 6'h08, A_TUNE = 6'h0C;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [2:0] speed_in = '0;
    logic vbus_in = 1'b0;
    logic [3:0] link_state_in = '0;
    logic dev_en, l1_en, u1_en, u2_en, force_fs, dma_clk_off, hs_clk_off, ss_clk_off;
    logic [6:0] func_addr;
    logic core_ready, tune_rx_hold;
    logic [7:0] tune_u1_det, tune_u1_gen;
    logic [4:0] tune_ping;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic cmp_next = 1'b0;

    always #5 clk = ~clk;

    dctl_regs #(.ADDR_W(AW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: one write, started at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Driver: one read; the expected word goes to the scoreboard.
    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Monitor: a read strobe seen at an edge makes data due at the next fall.
    always @(posedge clk) cmp_next <= bus_re;
    always @(negedge clk) begin
        if (cmp_next) begin
            if (exp_q.size() == 0) chk("scoreboard", 32'h1, 32'h0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 dev_en", {31'b0, dev_en}, 32'h0);
        chk("R8 clk off", {30'b0, hs_clk_off, ss_clk_off}, 32'h3);
        chk("R8 ready", {31'b0, core_ready}, 32'h1);
        rd(A_STS, 32'h0000_0700, "R8 status");
        rd(A_CFG, 32'h0, "R10 cfg reads 0");
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 32'h0);
        // R1 turn on
        wr(A_CFG, 32'h1 << 14);
        chk("R1 dev_en", {31'b0, dev_en}, 32'h1);
        rd(A_STS, 32'h0000_4700, "R1 status dev");
        // R2 zero write, R11 status write ignored
        wr(A_CFG, 32'h0);
        chk("R2 dev_en held", {31'b0, dev_en}, 32'h1);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, 32'h0000_4700, "R11 status write");
        // R3 both strobes
        wr(A_CFG, (32'h1 << 14) | (32'h1 << 15));
        chk("R3 dev_en", {31'b0, dev_en}, 32'h0);
        // R1 L1/U1/U2
        wr(A_CFG, (32'h1 << 16) | (32'h1 << 24) | (32'h1 << 26));
        chk("R1 l1 u1 u2", {29'b0, l1_en, u1_en, u2_en}, 32'h7);
        rd(A_STS, 32'h0301_0700, "R1 status l1 u1 u2");
        wr(A_CFG, 32'h1 << 25);
        rd(A_STS, 32'h0201_0700, "R1 u1 off");
        wr(A_CFG, (32'h1 << 17) | (32'h1 << 27));
        rd(A_STS, 32'h0000_0700, "R1 l1 u2 off");
        // R4 extra pairs
        wr(A_CFG, (32'h1 << 10) | (32'h1 << 13));
        chk("R4 dma force", {30'b0, dma_clk_off, force_fs}, 32'h3);
        rd(A_STS, 32'h4000_0700, "R4 status dma");
        wr(A_CFG, (32'h1 << 11) | (32'h1 << 12));
        chk("R4 dma force off", {30'b0, dma_clk_off, force_fs}, 32'h0);
        wr(A_CFG, 32'h1 << 19);
        rd(A_STS, 32'h0000_0600, "R4 hs clk off");
        wr(A_CFG, 32'h1 << 22);
        rd(A_STS, 32'h0000_0400, "R4 ss clk off");
        wr(A_CFG, (32'h1 << 18) | (32'h1 << 21));
        chk("R4 clk on", {30'b0, hs_clk_off, ss_clk_off}, 32'h3);
        // R5 function address
        wr(A_CMD, 32'h54);
        chk("R5 no commit", {25'b0, func_addr}, 32'h0);
        rd(A_STS, 32'h0000_0700, "R5 not addressed");
        wr(A_CMD, 32'h55);
        chk("R5 commit", {25'b0, func_addr}, 32'h2A);
        rd(A_STS, 32'h0000_8700, "R5 addressed");
        rd(A_CMD, 32'h0000_0054, "R5 cmd read");
        // R6 tuning fields
        wr(A_TUNE, 32'h012B_5AC3);
        chk("R6 det only", {tune_u1_det, tune_u1_gen, 10'b0, tune_rx_hold, tune_ping}, 32'hC300_0000);
        rd(A_TUNE, 32'h0000_00C3, "R6 partial read");
        wr(A_TUNE, 32'h0F2B_5AC3);
        chk("R6 all", {tune_u1_det, tune_u1_gen, 10'b0, tune_rx_hold, tune_ping}, 32'hC35A_0035);
        rd(A_TUNE, 32'h002B_5AC3, "R6 full read");
        // R7 external inputs
        speed_in = 3'd3; vbus_in = 1'b1; link_state_in = 4'd7;
        rd(A_STS, 32'h1C02_8730, "R7 high speed polling");
        speed_in = 3'd4; link_state_in = 4'd11;
        rd(A_STS, 32'h2C02_8740, "R7 super loopback");
        speed_in = '0; vbus_in = 1'b0; link_state_in = '0;
        // R9 software reset
        wr(A_CFG, (32'h1 << 14) | (32'h1 << 16) | (32'h1 << 19));
        rd(A_STS, 32'h0001_C600, "R9 preload");
        wr(A_CFG, (32'h1 << 7) | (32'h1 << 14));
        chk("R9 ready low", {31'b0, core_ready}, 32'h0);
        chk("R9 cleared", {24'b0, dev_en, l1_en, hs_clk_off, func_addr[4:0]}, 32'h20);
        for (int i = 0; i < 4; i++) rd(A_STS, 32'h0000_0300, "R9 window");
        rd(A_STS, 32'h0000_0700, "R9 released");
        rd(A_TUNE, 32'h002B_5AC3, "R9 tune kept");
        // R10 unmapped
        rd(6'h20, 32'h0, "R10 unmapped 0x20");
        rd(6'h3C, 32'h0, "R10 unmapped 0x3C");
        repeat (2) @(negedge clk);
        chk("scoreboard empty", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule